// File: doc/BRIEF.md
# SPI Register-Access Slave with Auto-Increment Burst

This block lets an external SPI host read and write a 128-entry, 8-bit register file. The host pulls the active-low select line low and shifts in a header. The header is one direction bit followed by a seven-bit register address. After the header comes one or more data bytes. While select stays low, the register address moves up by one after every byte. A long run of sequential registers can therefore be read or written with a single header. The address wraps from the top entry back to entry 0.

The SPI pins are asynchronous to the block. Select, serial clock and serial data-in each pass through a two-flop synchronizer into the system clock. Serial-clock edges are detected there, so the serial clock must run at no more than one quarter of the system clock rate. Data-in is sampled on the rising serial-clock edge, and data-out changes on the falling edge. During the data phase of a read, the block drives data-out and raises an output-enable flag. At all other times data-out is held low and the flag is low.

The SPI wires are the only data path at the block's edge. There is no valid/ready stream and no back-pressure. The host sets the pace, and every byte is accepted or returned in the serial-clock cycles the protocol allots to it.

Top module: `spi_reg_slave`

## Requirements
- R1: The first bit sampled after select falls is the direction bit: 1 selects a write transaction and 0 selects a read transaction.
- R2: The next seven bits are the register address, sent A6 first and A0 last.
- R3: Data bytes travel bit 7 first on both data-in and data-out. Data-in is taken on the rising serial-clock edge. Data-out is updated on the falling edge, so the first read bit is already valid before the first rising edge of the data phase.
- R4: In a write, a byte is stored at the current address only once all eight of its data bits have been received.
- R5: In a read, the value shifted out is the value currently stored at the addressed register.
- R6: While select stays low, the address advances by one after each byte, and reads or writes continue at the next register with no new header.
- R7: The address wraps from 127 to 0 during a burst.
- R8: The output-enable flag is high only in the data phase of a read. Whenever the flag is low, data-out is 0.
- R9: Data-in during the data phase of a read is ignored and changes no register.
- R10: Raising select at any point ends the transaction. A partly received byte is discarded, and the next transaction starts with a fresh header.
- R11: After reset, every register reads 0 and the output-enable flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 when not driving |
| spi_miso_oe | output | 1 | High while data-out carries read data |

## Verification
The bench uses the default parameters: a seven-bit address, eight-bit data and two synchronizer stages. This gives a 128-entry file, so the bench can run a burst that crosses the 127-to-0 wrap and also a single burst that covers the whole file and writes every entry. The serial clock runs at one twelfth of the system clock. That leaves enough margin after the synchronizer delay for the falling-edge read bit to settle before the host samples it. It also lets select be raised part-way through a header or a byte.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic {
    PH_HDR  = 1'b0,
    PH_DATA = 1'b1
  } spi_phase_e;

  localparam logic DIR_WRITE = 1'b1;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int              STAGES  = 2,
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_edge.sv
module spi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sclk_s;
  end

  assign rise = sclk_s & ~prev;
  assign fall = ~sclk_s & prev;
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          mosi_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          miso,
  output logic          miso_oe
);
  localparam int HDR_W = AW + 1;
  localparam int MAXB  = (HDR_W > DW) ? HDR_W : DW;
  localparam int CNT_W = (MAXB > 2) ? $clog2(MAXB) : 1;
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DW - 1);

  spi_phase_e       phase;
  logic [CNT_W-1:0] bit_cnt;
  logic [HDR_W-2:0] hdr_sr;
  logic [DW-2:0]    rx_sr;
  logic [DW-1:0]    tx_sr;
  logic [AW-1:0]    addr;
  logic             is_wr;

  logic [HDR_W-1:0] hdr_full;
  logic [DW-1:0]    rx_full;
  logic             hdr_last, dat_last;

  assign hdr_full = {hdr_sr, mosi_s};
  assign rx_full  = {rx_sr, mosi_s};
  assign hdr_last = (bit_cnt == HDR_LAST);
  assign dat_last = (bit_cnt == DAT_LAST);

  // Address whose value is preloaded for the next outgoing byte
  assign rd_addr = (phase == PH_HDR) ? hdr_full[AW-1:0] : addr + AW'(1);

  assign wr_en   = cs_act & sclk_rise & (phase == PH_DATA) & is_wr & dat_last;
  assign wr_addr = addr;
  assign wr_data = rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_HDR;
      bit_cnt <= '0;
      hdr_sr  <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      addr    <= '0;
      is_wr   <= 1'b0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (!cs_act) begin
      phase   <= PH_HDR;
      bit_cnt <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      if (sclk_rise) begin
        if (phase == PH_HDR) begin
          hdr_sr <= hdr_full[HDR_W-2:0];
          if (hdr_last) begin
            bit_cnt <= '0;
            phase   <= PH_DATA;
            is_wr   <= (hdr_full[HDR_W-1] == DIR_WRITE);
            addr    <= hdr_full[AW-1:0];
            tx_sr   <= rd_data;
          end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
          end
        end else begin
          rx_sr <= rx_full[DW-2:0];
          if (dat_last) begin
            bit_cnt <= '0;
            addr    <= addr + AW'(1);
            tx_sr   <= rd_data;
          end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
          end
        end
      end
      if (sclk_fall && phase == PH_DATA && !is_wr) begin
        miso    <= tx_sr[DW-1];
        tx_sr   <= {tx_sr[DW-2:0], 1'b0};
        miso_oe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic [2:0]        pins_s;
  logic              sclk_s, cs_n_s, mosi_s, cs_act;
  logic              sclk_rise, sclk_fall;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  spi_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sclk, spi_cs_n, spi_mosi}),
    .q     (pins_s)
  );

  assign sclk_s = pins_s[2];
  assign cs_n_s = pins_s[1];
  assign mosi_s = pins_s[0];
  assign cs_act = ~cs_n_s;

  spi_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_s (sclk_s),
    .rise   (sclk_rise),
    .fall   (sclk_fall)
  );

  spi_frame #(.AW(ADDR_W), .DW(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe)
  );

  spi_regfile #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              miso,
  input logic              miso_oe
);
  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_oe) else $error("oe high after deselect"); // R8

  AST_MISO_QUIET_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso) else $error("miso driven without oe"); // R8

  AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cs_act && sclk_rise)) else $error("write outside selected rise"); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1))) else $error("address did not step"); // R6

  AST_MISO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !sclk_fall) |=> $stable(miso)) else $error("miso moved off a falling edge"); // R3
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_act    (cs_act),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .miso      (spi_miso),
  .miso_oe   (spi_miso_oe)
);

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
  localparam int HALF  = 6;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, miso_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  spi_reg_slave dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sclk    (sclk),
    .spi_cs_n    (cs_n),
    .spi_mosi    (mosi),
    .spi_miso    (miso),
    .spi_miso_oe (miso_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    mosi = b;
    wait_clk(HALF);
    r = miso;
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic header(input logic dir, input int addr);
    logic r;
    logic [6:0] a;
    a = addr[6:0];
    cs_n = 1'b0;
    wait_clk(HALF);
    bit_x(dir, r);
    for (int i = 6; i >= 0; i--) bit_x(a[i], r);
  endtask

  task automatic end_frame();
    wait_clk(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(3 * HALF);
  endtask

  task automatic send_byte(input logic [7:0] d);
    logic r;
    for (int b = 7; b >= 0; b--) bit_x(d[b], r);
  endtask

  // Driver: writes a burst and updates the model
  task automatic burst_write(input int addr, input int n, input int seed);
    logic [7:0] d;
    header(1'b1, addr);
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 37);
      send_byte(d);
      model[(addr + i) % DEPTH] = d;
      if (i == 0) chk(miso_oe == 1'b0, "R8 oe low in write", miso_oe, 0);
    end
    end_frame();
  endtask

  // Driver: reads a burst, pushing expected and received bytes for the monitor
  task automatic burst_read(input int addr, input int n, input logic [7:0] fill, input string tag);
    logic [7:0] g;
    logic r;
    header(1'b0, addr);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        bit_x(fill[b], r);
        g[b] = r;
      end
      if (i == 0) chk(miso_oe == 1'b1, "R8 oe high in read data", miso_oe, 1);
      exp_q.push_back(model[(addr + i) % DEPTH]);
      tag_q.push_back(tag);
      got_q.push_back(g);
    end
    end_frame();
    chk(miso_oe == 1'b0 && miso == 1'b0, "R8 idle after read", {miso_oe, miso}, 0);
  endtask

  // Monitor: compares received read bytes against expectations
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] e, g;
        string t;
        e = exp_q.pop_front();
        g = got_q.pop_front();
        t = tag_q.pop_front();
        chk(g == e, t, g, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic r;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);

    // R11: reset state
    chk(miso_oe == 1'b0, "R11 oe after reset", miso_oe, 0);
    chk(miso == 1'b0, "R8 miso after reset", miso, 0);
    burst_read(0, 4, 8'h00, "R11 reset contents");

    // R1 R2 R4 R5: single writes to addresses differing in MSB/LSB
    burst_write(7'h40, 1, 8'hA5 - 0);
    burst_write(7'h01, 1, 8'h5A);
    burst_write(7'h05, 1, 8'hC3);
    burst_read(7'h40, 1, 8'h00, "R2 addr msb first");
    burst_read(7'h01, 1, 8'h00, "R1 R5 single read");
    burst_read(7'h05, 1, 8'h00, "R3 R4 byte msb first");

    // R6: burst write then burst read
    burst_write(20, 10, 8'h11);
    burst_read(20, 10, 8'h00, "R6 burst read");
    burst_read(23, 3, 8'h00, "R6 mid burst");

    // R7: wrap across 127
    burst_write(126, 4, 8'h70);
    burst_read(125, 5, 8'h00, "R7 wrap read");

    // R9: data-in activity during read ignored
    burst_read(20, 4, 8'hFF, "R9 read with ones");
    burst_read(20, 4, 8'h55, "R9 read with pattern");
    burst_read(20, 4, 8'h00, "R9 contents unchanged");

    // R10: abort in the middle of a data byte
    header(1'b1, 50);
    for (int b = 0; b < 5; b++) bit_x(1'b1, r);
    end_frame();
    burst_read(50, 1, 8'h00, "R10 partial byte dropped");

    // R10: abort in second byte keeps the first byte
    header(1'b1, 60);
    send_byte(8'h3C);
    model[60] = 8'h3C;
    for (int b = 0; b < 3; b++) bit_x(1'b1, r);
    end_frame();
    burst_read(60, 2, 8'h00, "R10 first byte kept");

    // R10: abort inside header, next transaction starts fresh
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int b = 0; b < 4; b++) bit_x(1'b1, r);
    end_frame();
    burst_read(7'h40, 1, 8'h00, "R10 fresh header");

    // R6 R7: whole file in one burst
    burst_write(100, DEPTH, 8'h2B);
    burst_read(100, DEPTH, 8'h00, "R7 full file burst");

    wait_clk(20);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule